// File: doc/BRIEF.md
# Hold-Signal Reset Type Controller

This block decides what happens when the processor's hold-power line goes low. Software programs an action code: warm restart, power-off or full hard restart. Software also sets an arming flag. When the flag is active and the hold line falls, the block asserts one action output and keeps it asserted. Power sequencing downstream of those outputs is not part of this block.

The arming flag does not follow a register write at once. An accepted write to the flag starts a settling window that lasts a fixed number of slow sleep-clock ticks. The flag takes its new value only when that window closes. Writes to the flag made during the window are discarded, and a busy bit reports the window to software. The expected programming order is: clear the flag, wait for busy to drop, write the action code, then set the flag again.

Which register holds the flag depends on a revision parameter. Revision zero keeps the flag beside the action code. Later revisions give it a register of its own.

Top module: `hold_reset_ctrl`

## Requirements
- R1: After reset, all three action outputs are 0. Reads of offsets 0x5A and 0x5B return 0x00.
- R2: Bits 3:0 of offset 0x5A hold the 4-bit action code, and a write there reads back in those bits. Bits 5:4 always read 0. The read data is registered: it shows the register selected by `bus_addr` at the previous clock edge.
- R3: For REVISION = 0, the arming flag is bit 7 of 0x5A and the busy bit is bit 6 of 0x5A, while 0x5B reads 0. For any other revision, the flag is bit 7 of 0x5B and busy is bit 6 of 0x5B, and bits 7:6 of 0x5A read 0. A write of bit 7 to 0x5A does not arm the block.
- R4: A write to the flag register while busy is 0 sets busy to 1. The flag (bit 7) keeps its old value until the third `sleep_tick` pulse after the write. On the clock edge of that pulse, the flag takes the written value and busy returns to 0.
- R5: A write to the flag register while busy is 1 has no effect on the flag. On revision 0, such a write still updates the action code.
- R6: `hold_in` passes through a two-stage synchronizer. While the flag is 1, a falling edge of `hold_in` asserts exactly one output: code 1 asserts `act_warm`, code 4 asserts `act_off`, code 7 asserts `act_hard`. The output is visible after the third clock edge that follows the input change.
- R7: A falling edge of `hold_in` while the flag is 0 asserts no output.
- R8: The reserved codes (0, 2, 3, 5, 6, 8 to 15) assert no output and do not block a later edge.
- R9: Once asserted, an action output stays asserted until reset. Later edges on `hold_in` and later changes of the action code do not alter the outputs.
- R10: Only a high-to-low transition acts. If `hold_in` is already low when the block becomes armed, or if `hold_in` rises, no output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous `bus_addr` |
| sleep_tick | input | 1 | One-cycle pulse for each sleep-clock period |
| hold_in | input | 1 | Asynchronous hold-power line from the processor |
| act_warm | output | 1 | Sticky warm-restart request |
| act_off | output | 1 | Sticky power-off request |
| act_hard | output | 1 | Sticky hard-restart request |

## Verification
The hardest situation to reach is a flag write that arrives while a settling window is already open. Catching the window requires counting sleep ticks exactly, because the window closes only on the third tick. The bench produces this case by issuing a clear and then, before any tick, a set. Once the three ticks have passed, it confirms that the clear took effect and the set was dropped. A second hard case is a reserved code followed by a valid one. The bench drives an edge under each of the sixteen codes, then rewrites the code to warm restart and drives a second edge. This second edge shows whether a reserved code wrongly blocked further action.

// File: rtl/hrc_pkg.sv
`timescale 1ns/1ps
package hrc_pkg;
  localparam logic [7:0] CTRL_OFS = 8'h5A;
  localparam logic [7:0] ARM_OFS  = 8'h5B;
  localparam int         ARM_BIT  = 7;
  localparam int         BUSY_BIT = 6;
  localparam int         CODE_W   = 4;

  localparam logic [CODE_W-1:0] CODE_WARM = 4'd1;
  localparam logic [CODE_W-1:0] CODE_OFF  = 4'd4;
  localparam logic [CODE_W-1:0] CODE_HARD = 4'd7;

  typedef struct packed {
    logic warm;
    logic off;
    logic hard;
  } action_t;
endpackage

// File: rtl/hrc_regs.sv
`timescale 1ns/1ps
module hrc_regs
  import hrc_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int REVISION     = 1,
  parameter int SETTLE_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              sleep_tick,
  output logic [7:0]        rdata,
  output logic [CODE_W-1:0] code,
  output logic              en_eff,
  output logic              busy
);
  localparam int CNT_W = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_ARM  = ADDR_W'(ARM_OFS);
  localparam logic [ADDR_W-1:0] A_EN   = (REVISION == 0) ? A_CTRL : A_ARM;
  localparam logic [CNT_W-1:0]  LAST   = CNT_W'(SETTLE_TICKS - 1);

  logic             en_wr;
  logic             code_wr;
  logic             pending;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       ctrl_view;
  logic [7:0]       arm_view;
  logic             unused_bits;

  assign en_wr       = wr && (addr == A_EN);
  assign code_wr     = wr && (addr == A_CTRL);
  assign unused_bits = ^wdata[5:4];

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
    end else if (code_wr) begin
      code <= wdata[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_eff  <= 1'b0;
      busy    <= 1'b0;
      pending <= 1'b0;
      cnt     <= '0;
    end else if (en_wr && !busy) begin
      pending <= wdata[ARM_BIT];
      busy    <= 1'b1;
      cnt     <= '0;
    end else if (busy && sleep_tick) begin
      if (cnt == LAST) begin
        en_eff <= pending;
        busy   <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  generate
    if (REVISION == 0) begin : g_shared
      assign ctrl_view = {en_eff, busy, 2'b00, code};
      assign arm_view  = 8'h00;
    end else begin : g_split
      assign ctrl_view = {4'h0, code};
      assign arm_view  = {en_eff, busy, 6'h00};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= 8'h00;
    end else if (addr == A_CTRL) begin
      rdata <= ctrl_view;
    end else if (addr == A_ARM) begin
      rdata <= arm_view;
    end else begin
      rdata <= 8'h00;
    end
  end
endmodule

// File: rtl/hrc_hold_sync.sv
`timescale 1ns/1ps
module hrc_hold_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_in,
  output logic fall
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[SYNC_STAGES-2:0], hold_in};
      prev  <= chain[SYNC_STAGES-1];
    end
  end

  assign fall = prev && !chain[SYNC_STAGES-1];
endmodule

// File: rtl/hrc_action.sv
`timescale 1ns/1ps
module hrc_action
  import hrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              en_eff,
  input  logic [CODE_W-1:0] code,
  output action_t           act
);
  logic fired;
  assign fired = act.warm | act.off | act.hard;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= '0;
    end else if (fall && en_eff && !fired) begin
      case (code)
        CODE_WARM: act.warm <= 1'b1;
        CODE_OFF:  act.off  <= 1'b1;
        CODE_HARD: act.hard <= 1'b1;
        default:   act      <= '0;
      endcase
    end
  end
endmodule

// File: rtl/hold_reset_ctrl.sv
`timescale 1ns/1ps
module hold_reset_ctrl
  import hrc_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int REVISION     = 1,
  parameter int SETTLE_TICKS = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              sleep_tick,
  input  logic              hold_in,
  output logic              act_warm,
  output logic              act_off,
  output logic              act_hard
);
  logic [CODE_W-1:0] code;
  logic              en_eff;
  logic              busy;
  logic              fall;
  action_t           act;

  hrc_regs #(
    .ADDR_W      (ADDR_W),
    .REVISION    (REVISION),
    .SETTLE_TICKS(SETTLE_TICKS)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .sleep_tick(sleep_tick),
    .rdata     (bus_rdata),
    .code      (code),
    .en_eff    (en_eff),
    .busy      (busy)
  );

  hrc_hold_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .hold_in(hold_in),
    .fall   (fall)
  );

  hrc_action u_action (
    .clk   (clk),
    .rst   (rst),
    .fall  (fall),
    .en_eff(en_eff),
    .code  (code),
    .act   (act)
  );

  assign act_warm = act.warm;
  assign act_off  = act.off;
  assign act_hard = act.hard;
endmodule

// File: rtl/hrc_checker.sv
`timescale 1ns/1ps
module hrc_checker (
  input logic       clk,
  input logic       rst,
  input logic       sleep_tick,
  input logic       en_eff,
  input logic       busy,
  input logic [2:0] act
);
  // R6: at most one action output
  a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(act));

  // R9: outputs frozen once any is set
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (act != 3'b000) |=> $stable(act));

  // R7: an action only appears while armed
  a_r7_armed: assert property (@(posedge clk) disable iff (rst)
    (act != 3'b000) && ($past(act) == 3'b000) |-> $past(en_eff));

  // R4: the arming flag changes only on a tick inside the settling window
  a_r4_flag_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(en_eff) |-> $past(busy && sleep_tick));

  // R5: the window cannot close without a tick
  a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
    busy && !sleep_tick |=> busy);
endmodule

bind hold_reset_ctrl hrc_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .sleep_tick(sleep_tick),
  .en_eff    (en_eff),
  .busy      (busy),
  .act       ({act_warm, act_off, act_hard})
);

// File: tb/hold_reset_ctrl_bench.sv
`timescale 1ns/1ps
module hold_reset_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_a = 1'b0;
  logic       wr_b = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       sleep_tick = 1'b0;
  logic       hold = 1'b1;
  logic [7:0] rd_a, rd_b;
  logic       wa, oa, ha, wb, ob, hb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hold_reset_ctrl #(.REVISION(1)) u_hold_reset_ctrl (
    .clk(clk), .rst(rst), .bus_wr(wr_a), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_a), .sleep_tick(sleep_tick), .hold_in(hold),
    .act_warm(wa), .act_off(oa), .act_hard(ha));

  hold_reset_ctrl #(.REVISION(0)) u_hold_reset_ctrl_rev0 (
    .clk(clk), .rst(rst), .bus_wr(wr_b), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_b), .sleep_tick(sleep_tick), .hold_in(hold),
    .act_warm(wb), .act_off(ob), .act_hard(hb));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_act(input int t);
    case (t)
      1: return 3'b100;
      4: return 3'b010;
      7: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic do_reset();
    rst = 1'b1; hold = 1'b1; wr_a = 0; wr_b = 0; sleep_tick = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_write(input bit a, input bit b, input logic [7:0] ad, input logic [7:0] d);
    addr = ad; wdata = d; wr_a = a; wr_b = b;
    @(negedge clk);
    wr_a = 0; wr_b = 0;
  endtask

  task automatic bus_read(input logic [7:0] ad, output logic [7:0] ra, output logic [7:0] rb);
    addr = ad;
    @(posedge clk);
    @(negedge clk);
    ra = rd_a; rb = rd_b;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      sleep_tick = 1'b1;
      @(negedge clk);
      sleep_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic set_hold(input logic v);
    hold = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] ra, rb;
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 acts A", {wa, oa, ha}, 0);
    chk("R1 acts B", {wb, ob, hb}, 0);
    bus_read(8'h5A, ra, rb);
    chk("R1 A 0x5A", ra, 8'h00);
    chk("R1 B 0x5A", rb, 8'h00);
    bus_read(8'h5B, ra, rb);
    chk("R1 A 0x5B", ra, 8'h00);

    // R2 / R3: code readback, bit7 at 0x5A does not arm revision 1
    bus_write(1, 0, 8'h5A, 8'hB5);
    bus_read(8'h5A, ra, rb);
    chk("R2 code readback", ra, 8'h05);
    ticks(3);
    bus_read(8'h5B, ra, rb);
    chk("R3 0x5A bit7 no arm", ra, 8'h00);

    // R4 settling window on revision 1
    bus_write(1, 0, 8'h5B, 8'h80);
    bus_read(8'h5B, ra, rb);
    chk("R4 busy after write", ra, 8'h40);
    ticks(2);
    bus_read(8'h5B, ra, rb);
    chk("R4 still busy after 2 ticks", ra, 8'h40);
    ticks(1);
    bus_read(8'h5B, ra, rb);
    chk("R4 armed after 3rd tick", ra, 8'h80);

    // R5 write during window dropped
    bus_write(1, 0, 8'h5B, 8'h00);
    bus_write(1, 0, 8'h5B, 8'h80);
    ticks(3);
    bus_read(8'h5B, ra, rb);
    chk("R5 second write dropped", ra, 8'h00);

    // R3 revision 0: flag beside code; R5 code still written while busy
    bus_write(0, 1, 8'h5A, 8'h87);
    bus_read(8'h5A, ra, rb);
    chk("R3 rev0 busy+code", rb, 8'h47);
    bus_write(0, 1, 8'h5A, 8'h02);
    bus_read(8'h5A, ra, rb);
    chk("R5 rev0 code updates while busy", rb, 8'h42);
    ticks(3);
    bus_read(8'h5A, ra, rb);
    chk("R3 rev0 armed", rb, 8'h82);
    bus_read(8'h5B, ra, rb);
    chk("R3 rev0 0x5B reads 0", rb, 8'h00);

    // R6 / R8 / R9 sweep over all sixteen codes on both revisions
    for (int t = 0; t < 16; t++) begin
      logic [2:0] first;
      do_reset();
      bus_write(1, 0, 8'h5A, 8'(t));
      bus_write(1, 0, 8'h5B, 8'h80);
      bus_write(0, 1, 8'h5A, 8'h80 | 8'(t));
      ticks(3);
      set_hold(1'b0);
      first = exp_act(t);
      chk($sformatf("R6 R8 A code %0d", t), {wa, oa, ha}, first);
      chk($sformatf("R6 R8 B code %0d", t), {wb, ob, hb}, first);
      bus_write(1, 0, 8'h5A, 8'h01);
      bus_write(0, 1, 8'h5A, 8'h81);
      ticks(3);
      set_hold(1'b1);
      set_hold(1'b0);
      if (first == 3'b000) begin
        chk($sformatf("R8 A reserved %0d no block", t), {wa, oa, ha}, 3'b100);
        chk($sformatf("R8 B reserved %0d no block", t), {wb, ob, hb}, 3'b100);
      end else begin
        chk($sformatf("R9 A sticky %0d", t), {wa, oa, ha}, first);
        chk($sformatf("R9 B sticky %0d", t), {wb, ob, hb}, first);
      end
    end

    // R7 not armed
    do_reset();
    bus_write(1, 1, 8'h5A, 8'h07);
    ticks(3);
    set_hold(1'b0);
    chk("R7 A unarmed", {wa, oa, ha}, 0);
    chk("R7 B unarmed", {wb, ob, hb}, 0);

    // R10 hold already low when armed, then rising
    do_reset();
    set_hold(1'b0);
    bus_write(1, 0, 8'h5A, 8'h04);
    bus_write(1, 0, 8'h5B, 8'h80);
    ticks(3);
    repeat (4) @(negedge clk);
    chk("R10 low level no act", {wa, oa, ha}, 0);
    set_hold(1'b1);
    chk("R10 rise no act", {wa, oa, ha}, 0);
    set_hold(1'b0);
    chk("R10 later fall acts", {wa, oa, ha}, 3'b010);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule